// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers six interrupt sources onto a sixteen-line ISA-style IRQ vector. Four of them are active-low PCI interrupt lines; the other two are active-high plug-and-play requests. Software programs a 4-bit target IRQ number for every source, and a mode bit for every PCI line. Software then reads the settings back through a small byte-wide configuration port.

Each PCI line works in one of two modes, chosen by its mode bit:

- **Level mode:** the line is passed through as a level.
- **Edge mode:** the line is inverted to active-high, and every assertion produces a single-cycle pulse.

Target numbers 0, 2 and 13 belong to the system and are never driven. When several sources share one target, their requests are ORed. Every IRQ output comes from a flop, so it follows its sources one clock later.

Top module: `pirq_router`

## Requirements
- R1: After reset, every route nibble and every mode bit is 0. All irq_o lines stay low even when every source is asserted.
- R2: A write with cfg_we high stores cfg_wdata in the byte selected by cfg_addr at the next rising clock. cfg_rdata returns that byte combinationally for the current cfg_addr.
- R3: Address 3 is the mode byte: bit 3 is INTA, bit 2 INTB, bit 1 INTC, bit 0 INTD. Bits 7:4 are not stored and read as 0.
- R4: Route bytes use these addresses and fields. Address 0 holds INTA in bits 7:4 and INTB in bits 3:0. Address 1 holds INTC in 7:4 and PIRQ1 in 3:0. Address 2 holds INTD in 7:4 and PIRQ0 in 3:0. A nibble value N names irq_o[N]. pci_int_n bit 0..3 is INTA..INTD, and pnp_req bit 0/1 is PIRQ0/PIRQ1.
- R5: In level mode (mode bit 0), the routed irq_o bit is high one clock after pci_int_n is sampled low. It stays high while the line stays low and falls one clock after the line is released.
- R6: In edge mode (mode bit 1), each high-to-low transition of pci_int_n produces a pulse of exactly one clock on the routed irq_o bit. A line held low produces no further pulse.
- R7: A source routed to 0, 2 or 13 drives no output, and irq_o[0], irq_o[2] and irq_o[13] are never high.
- R8: When several asserted sources name the same target, that irq_o bit is the OR of their requests. Sources with different targets appear independently.
- R9: pnp_req bits are active-high levels. They reach their routed irq_o bit one clock later, whatever the PCI mode bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Configuration byte select (0..2 routes, 3 modes) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| pci_int_n | input | 4 | PCI interrupt lines INTA..INTD, active low |
| pnp_req | input | 2 | Plug-and-play requests PIRQ0, PIRQ1, active high |
| irq_o | output | 16 | Steered IRQ vector |

## Verification
- **Corrupted route nibble:** shows up one clock after the next assertion of that source, as a wrong bit set in irq_o or the expected bit missing. The readback port exposes the same fault with no latency at all.
- **Stuck edge-history flop:** shows up as a pulse that lasts more than one clock, or as no pulse at all, on the cycle after an assertion.
- **Broken reserved-number filter:** shows up one clock after any source is routed to 0, 2 or 13 and asserted.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int IRQ_W   = 16;
  localparam int SEL_W   = $clog2(IRQ_W);
  localparam int NUM_PCI = 4;
  localparam int NUM_PNP = 2;
  localparam int NUM_SRC = NUM_PCI + NUM_PNP;
  localparam int CFG_AW  = 2;
  localparam int CFG_DW  = 8;
  localparam int NUM_RTB = 3;

  // source indices in the internal request vector
  localparam int SRC_A  = 0;
  localparam int SRC_B  = 1;
  localparam int SRC_C  = 2;
  localparam int SRC_D  = 3;
  localparam int SRC_P0 = 4;
  localparam int SRC_P1 = 5;

  // configuration byte addresses
  localparam logic [CFG_AW-1:0] ADDR_AB  = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_CP1 = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_DP0 = 2'd2;
  localparam logic [CFG_AW-1:0] ADDR_MOD = 2'd3;

  typedef logic [SEL_W-1:0] sel_t;

  function automatic logic sel_reserved(input sel_t s);
    return (s == sel_t'(0)) || (s == sel_t'(2)) || (s == sel_t'(13));
  endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int DW = CFG_DW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  output logic [NUM_SRC-1:0][SEL_W-1:0] route_o,
  output logic [NUM_PCI-1:0]            edge_mode_o
);

  logic [NUM_RTB-1:0][DW-1:0] rtb_q;
  logic [NUM_RTB-1:0][DW-1:0] rtb_d;
  logic [NUM_RTB-1:0]         rtb_en;
  logic [NUM_PCI-1:0]         mod_q;
  logic [NUM_PCI-1:0]         mod_d;
  logic                       mod_en;

  // next-state and enables
  always_comb begin
    for (int k = 0; k < NUM_RTB; k++) begin
      rtb_en[k] = we_i && (addr_i == AW'(k));
      rtb_d[k]  = wdata_i;
    end
    mod_en = we_i && (addr_i == ADDR_MOD);
    // mode byte: bit3=A, bit2=B, bit1=C, bit0=D
    for (int p = 0; p < NUM_PCI; p++) begin
      mod_d[p] = wdata_i[NUM_PCI-1-p];
    end
  end

  generate
    for (genvar g = 0; g < NUM_RTB; g++) begin : g_rtb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rtb_q[g] <= '0;
        end else if (rtb_en[g]) begin
          rtb_q[g] <= rtb_d[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
    end else if (mod_en) begin
      mod_q <= mod_d;
    end
  end

  // field unpacking; positions are decoded by software
  always_comb begin
    route_o[SRC_A]  = rtb_q[ADDR_AB][DW-1:SEL_W];
    route_o[SRC_B]  = rtb_q[ADDR_AB][SEL_W-1:0];
    route_o[SRC_C]  = rtb_q[ADDR_CP1][DW-1:SEL_W];
    route_o[SRC_P1] = rtb_q[ADDR_CP1][SEL_W-1:0];
    route_o[SRC_D]  = rtb_q[ADDR_DP0][DW-1:SEL_W];
    route_o[SRC_P0] = rtb_q[ADDR_DP0][SEL_W-1:0];
    edge_mode_o     = mod_q;
  end

  // readback
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_AB:  rdata_o = rtb_q[ADDR_AB];
      ADDR_CP1: rdata_o = rtb_q[ADDR_CP1];
      ADDR_DP0: rdata_o = rtb_q[ADDR_DP0];
      default: begin
        for (int p = 0; p < NUM_PCI; p++) begin
          rdata_o[NUM_PCI-1-p] = mod_q[p];
        end
      end
    endcase
  end

  // R2: a write to the first route byte lands in both source fields
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_AB) |=>
      (route_o[SRC_A] == $past(wdata_i[DW-1:SEL_W])) &&
      (route_o[SRC_B] == $past(wdata_i[SEL_W-1:0])));

  // R3: mode writes change only the mode flags, never a route
  assert_mode_write_keeps_routes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_MOD) |=> $stable(route_o));

endmodule

// File: rtl/pirq_line_cond.sv
module pirq_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic int_n_i,
  input  logic edge_mode_i,
  output logic req_o
);

  logic prev_n_q;
  logic prev_n_d;
  logic lvl_req;
  logic edg_req;

  always_comb begin
    prev_n_d = int_n_i;
    lvl_req  = ~int_n_i;
    edg_req  = ~int_n_i & prev_n_q;
    req_o    = edge_mode_i ? edg_req : lvl_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n_q <= 1'b1;
    end else begin
      prev_n_q <= prev_n_d;
    end
  end

  // R6: an edge-mode request never lasts two consecutive cycles
  assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && req_o) |=> (!req_o || !edge_mode_i));

endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int NIRQ = IRQ_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            src_req_i,
  input  logic [NSRC-1:0][SEL_W-1:0] route_i,
  output logic [NIRQ-1:0]            irq_o
);

  logic [NIRQ-1:0] irq_d;
  logic [NIRQ-1:0] irq_q;

  always_comb begin
    irq_d = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_req_i[s] && !sel_reserved(route_i[s])) begin
        irq_d[route_i[s]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R7: system-owned lines stay quiet
  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q[0] && !irq_q[2] && !irq_q[13]);

  // R8: every live request on a usable target shows on that line next cycle
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_chk_src
      for (genvar k = 0; k < NIRQ; k++) begin : g_chk_irq
        if (k != 0 && k != 2 && k != 13) begin : g_use
          assert_route_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (src_req_i[s] && route_i[s] == SEL_W'(k)) |=> irq_q[k]);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  output logic [CFG_DW-1:0]   cfg_rdata,
  input  logic [NUM_PCI-1:0]  pci_int_n,
  input  logic [NUM_PNP-1:0]  pnp_req,
  output logic [IRQ_W-1:0]    irq_o
);

  logic [1:0]                 rst_sync_q;
  logic                       rst_int_n;
  logic [NUM_SRC-1:0][SEL_W-1:0] route;
  logic [NUM_PCI-1:0]         edge_mode;
  logic [NUM_PCI-1:0]         pci_req;
  logic [NUM_SRC-1:0]         src_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pirq_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .we_i        (cfg_we),
    .addr_i      (cfg_addr),
    .wdata_i     (cfg_wdata),
    .rdata_o     (cfg_rdata),
    .route_o     (route),
    .edge_mode_o (edge_mode)
  );

  generate
    for (genvar p = 0; p < NUM_PCI; p++) begin : g_line
      pirq_line_cond u_cond (
        .clk         (clk),
        .rst_n       (rst_int_n),
        .int_n_i     (pci_int_n[p]),
        .edge_mode_i (edge_mode[p]),
        .req_o       (pci_req[p])
      );
    end
  endgenerate

  assign src_req = {pnp_req, pci_req};

  pirq_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .src_req_i (src_req),
    .route_i   (route),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/sim_pirq_router.sv
module sim_pirq_router;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int NVEC       = 7;

  // {route AB, route CP1, route DP0, pci_int_n, pnp_req, expected irq}
  localparam logic [45:0] VEC [0:NVEC-1] = '{
    {8'h35, 8'h79, 8'hB4, 4'b0000, 2'b11, 16'h0AB8},
    {8'h35, 8'h79, 8'hB4, 4'b1110, 2'b00, 16'h0008},
    {8'h35, 8'h79, 8'hB4, 4'b1111, 2'b10, 16'h0200},
    {8'hAA, 8'hAA, 8'hAA, 4'b1101, 2'b00, 16'h0400},
    {8'h02, 8'hD0, 8'h2D, 4'b0000, 2'b11, 16'h0000},
    {8'hF1, 8'hE3, 8'h0C, 4'b0000, 2'b01, 16'hD002},
    {8'hF1, 8'hE3, 8'h0C, 4'b1111, 2'b00, 16'h0000}
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pci_int_n;
  logic [1:0]  pnp_req;
  logic [15:0] irq_o;

  int n_chk;
  int n_fail;

  pirq_router u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pci_int_n (pci_int_n),
    .pnp_req   (pnp_req),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  task automatic step_chk(input string tag, input logic [15:0] exp);
    @(posedge clk);
    @(negedge clk);
    chk(tag, irq_o, exp);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = 2'd0;
    cfg_wdata = 8'h00;
    pci_int_n = 4'b1111;
    pnp_req   = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", irq_o, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: cleared configuration, all sources asserted, nothing driven
    read_chk("R1 rd addr0", 2'd0, 8'h00);
    read_chk("R1 rd addr1", 2'd1, 8'h00);
    read_chk("R1 rd addr2", 2'd2, 8'h00);
    read_chk("R1 rd addr3", 2'd3, 8'h00);
    pci_int_n = 4'b0000;
    pnp_req   = 2'b11;
    @(posedge clk);
    step_chk("R1 no route after reset", 16'h0000);
    pci_int_n = 4'b1111;
    pnp_req   = 2'b00;

    // R2 / R3: readback and mode-byte masking
    cfg_write(2'd0, 8'hC9);
    read_chk("R2 rd back addr0", 2'd0, 8'hC9);
    cfg_write(2'd3, 8'hFF);
    read_chk("R3 upper mode bits read 0", 2'd3, 8'h0F);
    read_chk("R3 mode write left addr0", 2'd0, 8'hC9);
    cfg_write(2'd3, 8'h00);

    // table walk: R4 field packing, R5 level, R7 reserved, R8 merge, R9 pnp
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(2'd0, VEC[i][45:38]);
      cfg_write(2'd1, VEC[i][37:30]);
      cfg_write(2'd2, VEC[i][29:22]);
      @(negedge clk);
      pci_int_n = VEC[i][21:18];
      pnp_req   = VEC[i][17:16];
      step_chk($sformatf("R4 R5 R7 R8 R9 vector %0d", i), VEC[i][15:0]);
    end
    pci_int_n = 4'b1111;
    pnp_req   = 2'b00;

    // R6 vs R5: INTA edge mode to 5, INTB level mode to 6
    cfg_write(2'd0, 8'h56);
    cfg_write(2'd1, 8'h00);
    cfg_write(2'd2, 8'h00);
    cfg_write(2'd3, 8'h08);
    repeat (2) @(negedge clk);
    pci_int_n = 4'b1100;
    step_chk("R6 edge pulse start", 16'h0060);
    step_chk("R6 pulse one cycle R5 level held", 16'h0040);
    step_chk("R6 no repeat while held", 16'h0040);
    pci_int_n = 4'b1111;
    step_chk("R5 level released", 16'h0000);
    @(negedge clk);
    pci_int_n = 4'b1110;
    step_chk("R6 second edge pulse", 16'h0020);
    step_chk("R6 second pulse ends", 16'h0000);

    // R9: pnp unaffected by mode bits; R8 merge of edge pulse and pnp level
    cfg_write(2'd2, 8'h05);
    @(negedge clk);
    pnp_req   = 2'b01;
    pci_int_n = 4'b1111;
    step_chk("R9 pnp level with mode bits set", 16'h0020);
    pci_int_n = 4'b1110;
    step_chk("R8 merge pulse with pnp", 16'h0020);
    pnp_req = 2'b00;
    step_chk("R9 pnp released", 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule